// File: doc/BRIEF.md
# Method-Call Packet Dispatch Router

This router sits between a set of callers that invoke methods on objects and a set of functional units that each implement one method of one class. A caller presents a call made of a method number, an object reference (a class number plus an instance number inside that class) and one parameter word. The router joins the method and class numbers into an 8-bit unit address. It compares that address with the address configured for each unit port and forwards the instance number, the parameter word and the caller's port index (the tag) to the matching unit. Selecting the implementation from the object's class therefore happens as part of routing, and no lookup table is needed.

A unit returns its result as a separate packet that carries the tag it received. The router steers that packet back to the caller port named by the tag. Every data path is valid/ready. A source that raises valid holds it, with stable payload, until ready is seen high at a clock edge. A stalled receiver stalls only its own path. A unit accepts at most one call at a time. The router drives one activity flag per unit, which power control can use to switch off idle units.

Top module: `method_dispatch_router`

## Requirements
- R1: The unit address of a call is {method, class}, with the method in bits 7:4 and the class in bits 3:0. A call is presented on the unit port whose configured address equals it, with the instance number and parameter word unchanged. By default units 0..3 have addresses 0x10, 0x11, 0x20 and 0x31.
- R2: The tag presented to a unit equals the index of the caller port that issued the call.
- R3: A unit result with tag t appears on caller port t, in the same cycle, with the error flag low and the data unchanged.
- R4: A call whose address matches no unit is accepted at once and reaches no unit. In the next cycle its caller port presents a response with the error flag high and data zero.
- R5: Callers that request the same unit are served round-robin. The search starts one caller past the last one granted, and after reset it starts at caller 0.
- R6: While a unit's request is valid and its ready is low, the request stays valid with the same tag, instance and parameter, even when other callers raise requests for that unit.
- R7: After a unit accepts a call, no further request is presented to it, and competing callers see ready low, until its result has been accepted by the caller.
- R8: A unit's active flag is low after reset. It is high from the cycle after the unit accepts a call through the cycle in which the caller accepts that call's result.
- R9: While a caller's response is valid and its ready is low, the response stays valid with stable data and error flag, and the unit result behind it is not consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_valid | input | NC | Call request valid, one bit per caller |
| call_ready | output | NC | Call accepted |
| call_method | input | NC*4 | Method number per caller |
| call_class | input | NC*4 | Class number of the object per caller |
| call_inst | input | NC*8 | Instance number of the object per caller |
| call_param | input | NC*32 | Parameter word per caller |
| rsp_valid | output | NC | Response valid per caller |
| rsp_ready | input | NC | Caller accepts response |
| rsp_data | output | NC*32 | Response data per caller |
| rsp_err | output | NC | Response flags an unroutable call |
| fu_req_valid | output | NF | Call packet valid per unit |
| fu_req_ready | input | NF | Unit accepts call packet |
| fu_req_inst | output | NF*8 | Instance number to unit |
| fu_req_param | output | NF*32 | Parameter word to unit |
| fu_req_tag | output | NF*TW | Issuing caller index |
| fu_res_valid | input | NF | Result packet valid per unit |
| fu_res_ready | output | NF | Result consumed by router |
| fu_res_data | input | NF*32 | Result data per unit |
| fu_res_tag | input | NF*TW | Caller index echoed by unit |
| fu_active | output | NF | Unit holds an outstanding call |

## Verification
The hardest case to reach from the ports is a unit whose result is blocked by a stalled caller while another caller is already waiting for that same unit. In that case the unit must stay active and the waiting caller must stay stalled. The bench gets there by first holding a unit's ready low, so that a second caller queues behind a held grant. It then returns the result with the first caller's response ready low for several cycles. A full sweep of every caller against every method and class pair covers each hit and each miss of the address decode.

// File: rtl/mdr_pkg.sv
package mdr_pkg;
  localparam int METH_W_D  = 4;
  localparam int CLASS_W_D = 4;
  localparam int INST_W_D  = 8;
  localparam int PARAM_W_D = 32;
endpackage

// File: rtl/mdr_rr_arb.sv
module mdr_rr_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         stall,
  input  logic         advance,
  output logic [N-1:0] gnt,
  output logic         holding
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] ptr_q;
  logic [N-1:0]  last_q;
  logic          hold_q;
  logic [N-1:0]  pick;
  logic          found;
  logic [IW-1:0] gidx;
  logic [IW-1:0] nxt;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int o = 0; o < N; o++) begin
      int j;
      j = (int'(ptr_q) + o) % N;
      if (!found && req[j]) begin
        pick[j] = 1'b1;
        found   = 1'b1;
      end
    end
  end

  assign gnt     = hold_q ? last_q : pick;
  assign holding = hold_q;

  always_comb begin
    gidx = '0;
    for (int i = 0; i < N; i++) begin
      if (gnt[i]) gidx = IW'(i);
    end
    nxt = (gidx == IW'(N - 1)) ? '0 : gidx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      last_q <= '0;
      hold_q <= 1'b0;
    end else begin
      hold_q <= stall;
      last_q <= gnt;
      if (advance) ptr_q <= nxt;
    end
  end

  assert_gnt_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
endmodule

// File: rtl/mdr_decode.sv
module mdr_decode #(
  parameter int NF    = 4,
  parameter int FUA_W = 8,
  parameter logic [NF*FUA_W-1:0] FU_ADDR = '0
) (
  input  logic [FUA_W-1:0] addr,
  output logic [NF-1:0]    hit,
  output logic             miss
);
  for (genvar f = 0; f < NF; f++) begin : g_cmp
    assign hit[f] = (addr == FU_ADDR[f*FUA_W +: FUA_W]);
  end
  assign miss = ~|hit;
endmodule

// File: rtl/mdr_fu_port.sv
module mdr_fu_port #(
  parameter int NC      = 4,
  parameter int TW      = 2,
  parameter int INST_W  = 8,
  parameter int PARAM_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NC-1:0]         call_valid,
  input  logic [NC-1:0]         dest_hit,
  input  logic [NC*INST_W-1:0]  call_inst,
  input  logic [NC*PARAM_W-1:0] call_param,
  input  logic                  req_ready,
  input  logic                  res_fire,
  output logic                  req_valid,
  output logic [INST_W-1:0]     req_inst,
  output logic [PARAM_W-1:0]    req_param,
  output logic [TW-1:0]         req_tag,
  output logic [NC-1:0]         gnt,
  output logic                  active
);
  logic          busy_q;
  logic [NC-1:0] cand;
  logic          arb_hold;

  assign cand = call_valid & dest_hit & {NC{~busy_q}};

  mdr_rr_arb #(.N(NC)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (cand),
    .stall   (req_valid & ~req_ready),
    .advance (req_valid & req_ready),
    .gnt     (gnt),
    .holding (arb_hold)
  );

  assign req_valid = |(gnt & cand);

  always_comb begin
    req_inst  = '0;
    req_param = '0;
    req_tag   = '0;
    for (int c = 0; c < NC; c++) begin
      if (gnt[c]) begin
        req_inst  = call_inst[c*INST_W +: INST_W];
        req_param = call_param[c*PARAM_W +: PARAM_W];
        req_tag   = TW'(c);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      busy_q <= 1'b0;
    else if (req_valid && req_ready) busy_q <= 1'b1;
    else if (res_fire)               busy_q <= 1'b0;
  end

  assign active = busy_q;

  assert_hold_path_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready && !arb_hold |=> req_valid && $stable(req_tag)
      && $stable(req_param) && $stable(req_inst));
  assert_one_outstanding_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_valid);
  assert_active_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> active);
  assert_active_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    active && !res_fire |=> active);
endmodule

// File: rtl/mdr_ret_port.sv
module mdr_ret_port #(
  parameter int NF      = 4,
  parameter int PARAM_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NF-1:0]         res_mine,
  input  logic [NF*PARAM_W-1:0] res_data,
  input  logic                  err_set,
  input  logic                  rsp_ready,
  output logic                  rsp_valid,
  output logic [PARAM_W-1:0]    rsp_data,
  output logic                  rsp_err,
  output logic [NF-1:0]         take,
  output logic                  err_pend
);
  logic          err_q;
  logic          arb_hold;
  logic          sel_err;
  logic [NF-1:0] cand;
  logic [NF-1:0] gnt;
  logic          res_sel;

  assign sel_err = err_q & ~arb_hold;
  assign cand    = sel_err ? '0 : res_mine;
  assign res_sel = |(gnt & cand);

  mdr_rr_arb #(.N(NF)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (cand),
    .stall   (res_sel & ~rsp_ready),
    .advance (res_sel & rsp_ready),
    .gnt     (gnt),
    .holding (arb_hold)
  );

  assign rsp_valid = sel_err | res_sel;
  assign rsp_err   = sel_err;
  assign take      = gnt & cand & {NF{rsp_ready}};
  assign err_pend  = err_q;

  always_comb begin
    rsp_data = '0;
    for (int f = 0; f < NF; f++) begin
      if (gnt[f] && cand[f]) rsp_data = res_data[f*PARAM_W +: PARAM_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                    err_q <= 1'b0;
    else if (err_set)              err_q <= 1'b1;
    else if (sel_err && rsp_ready) err_q <= 1'b0;
  end

  assert_miss_reply_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_set && !(rsp_valid && !rsp_ready) |=> rsp_valid && rsp_err);
  assert_rsp_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_err));
endmodule

// File: rtl/method_dispatch_router.sv
module method_dispatch_router #(
  parameter int NC      = 4,
  parameter int NF      = 4,
  parameter int METH_W  = mdr_pkg::METH_W_D,
  parameter int CLASS_W = mdr_pkg::CLASS_W_D,
  parameter int INST_W  = mdr_pkg::INST_W_D,
  parameter int PARAM_W = mdr_pkg::PARAM_W_D,
  parameter int TW      = (NC > 1) ? $clog2(NC) : 1,
  parameter logic [NF*(METH_W+CLASS_W)-1:0] FU_ADDR = 32'h3120_1110
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NC-1:0]           call_valid,
  output logic [NC-1:0]           call_ready,
  input  logic [NC*METH_W-1:0]    call_method,
  input  logic [NC*CLASS_W-1:0]   call_class,
  input  logic [NC*INST_W-1:0]    call_inst,
  input  logic [NC*PARAM_W-1:0]   call_param,
  output logic [NC-1:0]           rsp_valid,
  input  logic [NC-1:0]           rsp_ready,
  output logic [NC*PARAM_W-1:0]   rsp_data,
  output logic [NC-1:0]           rsp_err,
  output logic [NF-1:0]           fu_req_valid,
  input  logic [NF-1:0]           fu_req_ready,
  output logic [NF*INST_W-1:0]    fu_req_inst,
  output logic [NF*PARAM_W-1:0]   fu_req_param,
  output logic [NF*TW-1:0]        fu_req_tag,
  input  logic [NF-1:0]           fu_res_valid,
  output logic [NF-1:0]           fu_res_ready,
  input  logic [NF*PARAM_W-1:0]   fu_res_data,
  input  logic [NF*TW-1:0]        fu_res_tag,
  output logic [NF-1:0]           fu_active
);
  localparam int FUA_W = METH_W + CLASS_W;

  logic [NF-1:0] hit_row  [NC];
  logic [NC-1:0] hit_col  [NF];
  logic [NC-1:0] fu_gnt   [NF];
  logic [NF-1:0] ret_take [NC];
  logic [NC-1:0] miss;
  logic [NC-1:0] err_pend;
  logic [NF-1:0] res_fire;

  // address formation and decode, one per caller
  for (genvar c = 0; c < NC; c++) begin : g_dec
    mdr_decode #(.NF(NF), .FUA_W(FUA_W), .FU_ADDR(FU_ADDR)) u_dec (
      .addr ({call_method[c*METH_W +: METH_W], call_class[c*CLASS_W +: CLASS_W]}),
      .hit  (hit_row[c]),
      .miss (miss[c])
    );
  end

  always_comb begin
    for (int f = 0; f < NF; f++) begin
      for (int c = 0; c < NC; c++) hit_col[f][c] = hit_row[c][f];
    end
  end

  assign res_fire = fu_res_valid & fu_res_ready;

  // forward path, one per unit
  for (genvar f = 0; f < NF; f++) begin : g_fu
    mdr_fu_port #(.NC(NC), .TW(TW), .INST_W(INST_W), .PARAM_W(PARAM_W)) u_fu (
      .clk        (clk),
      .rst_n      (rst_n),
      .call_valid (call_valid),
      .dest_hit   (hit_col[f]),
      .call_inst  (call_inst),
      .call_param (call_param),
      .req_ready  (fu_req_ready[f]),
      .res_fire   (res_fire[f]),
      .req_valid  (fu_req_valid[f]),
      .req_inst   (fu_req_inst[f*INST_W +: INST_W]),
      .req_param  (fu_req_param[f*PARAM_W +: PARAM_W]),
      .req_tag    (fu_req_tag[f*TW +: TW]),
      .gnt        (fu_gnt[f]),
      .active     (fu_active[f])
    );
  end

  // return path, one per caller
  for (genvar c = 0; c < NC; c++) begin : g_ret
    logic [NF-1:0] mine;
    for (genvar f = 0; f < NF; f++) begin : g_tag
      assign mine[f] = fu_res_valid[f] && (fu_res_tag[f*TW +: TW] == TW'(c));
    end
    mdr_ret_port #(.NF(NF), .PARAM_W(PARAM_W)) u_ret (
      .clk       (clk),
      .rst_n     (rst_n),
      .res_mine  (mine),
      .res_data  (fu_res_data),
      .err_set   (call_valid[c] & miss[c] & ~err_pend[c]),
      .rsp_ready (rsp_ready[c]),
      .rsp_valid (rsp_valid[c]),
      .rsp_data  (rsp_data[c*PARAM_W +: PARAM_W]),
      .rsp_err   (rsp_err[c]),
      .take      (ret_take[c]),
      .err_pend  (err_pend[c])
    );
  end

  always_comb begin
    for (int f = 0; f < NF; f++) begin
      fu_res_ready[f] = 1'b0;
      for (int c = 0; c < NC; c++) fu_res_ready[f] = fu_res_ready[f] | ret_take[c][f];
    end
    for (int c = 0; c < NC; c++) begin
      logic acc;
      acc = 1'b0;
      for (int f = 0; f < NF; f++) begin
        acc = acc | (fu_gnt[f][c] & fu_req_valid[f] & fu_req_ready[f]);
      end
      call_ready[c] = miss[c] ? ~err_pend[c] : acc;
    end
  end

  assert_active_reset_R8: assert property (@(posedge clk)
    $fell(rst_n) |=> fu_active == '0);
  assert_result_routed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fu_res_valid & fu_res_ready) != '0 |-> (rsp_valid & ~rsp_err & rsp_ready) != '0);
endmodule

// File: tb/method_dispatch_router_tb_top.sv
`timescale 1ns/1ps
module method_dispatch_router_tb_top;
  localparam int NC = 4, NF = 4, TW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [NC-1:0]    call_valid = '0, call_ready;
  logic [NC*4-1:0]  call_method = '0, call_class = '0;
  logic [NC*8-1:0]  call_inst = '0;
  logic [NC*32-1:0] call_param = '0;
  logic [NC-1:0]    rsp_valid, rsp_err;
  logic [NC-1:0]    rsp_ready = '1;
  logic [NC*32-1:0] rsp_data;
  logic [NF-1:0]    fu_req_valid, fu_res_ready, fu_active;
  logic [NF-1:0]    fu_req_ready = '1, fu_res_valid = '0;
  logic [NF*8-1:0]  fu_req_inst;
  logic [NF*32-1:0] fu_req_param;
  logic [NF*TW-1:0] fu_req_tag;
  logic [NF*32-1:0] fu_res_data = '0;
  logic [NF*TW-1:0] fu_res_tag = '0;

  method_dispatch_router dut_i (
    .clk(clk), .rst_n(rst_n),
    .call_valid(call_valid), .call_ready(call_ready),
    .call_method(call_method), .call_class(call_class),
    .call_inst(call_inst), .call_param(call_param),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_err(rsp_err),
    .fu_req_valid(fu_req_valid), .fu_req_ready(fu_req_ready),
    .fu_req_inst(fu_req_inst), .fu_req_param(fu_req_param), .fu_req_tag(fu_req_tag),
    .fu_res_valid(fu_res_valid), .fu_res_ready(fu_res_ready),
    .fu_res_data(fu_res_data), .fu_res_tag(fu_res_tag),
    .fu_active(fu_active)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // unit addresses from R1: {method, class}
  function automatic int exp_fu(input int m, input int k);
    int am[4] = '{1, 1, 2, 3};
    int ak[4] = '{0, 1, 0, 1};
    for (int f = 0; f < NF; f++) if (am[f] == m && ak[f] == k) return f;
    return -1;
  endfunction

  task automatic set_call(input int c, input int m, input int k, input logic [7:0] inst, input logic [31:0] p);
    call_method[c*4 +: 4] = 4'(m);
    call_class[c*4 +: 4]  = 4'(k);
    call_inst[c*8 +: 8]   = inst;
    call_param[c*32 +: 32] = p;
    call_valid[c] = 1'b1;
  endtask

  task automatic one_call(input int c, input int m, input int k);
    logic [7:0]  inst;
    logic [31:0] p;
    int e;
    inst = 8'((m * 16 + k) ^ c);
    p = 32'hA500_0000 + 32'(c << 16) + 32'(m << 8) + 32'(k * 3);
    e = exp_fu(m, k);
    @(negedge clk);
    set_call(c, m, k, inst, p);
    #1;
    if (e >= 0) begin
      chk(fu_req_valid == NF'(1 << e), "R1 unit select", 32'(fu_req_valid), 32'(1 << e));
      chk(fu_req_inst[e*8 +: 8] == inst && fu_req_param[e*32 +: 32] == p, "R1 payload",
          fu_req_param[e*32 +: 32], p);
      chk(fu_req_tag[e*TW +: TW] == TW'(c), "R2 tag", 32'(fu_req_tag[e*TW +: TW]), 32'(c));
      @(posedge clk);
      @(negedge clk);
      call_valid[c] = 1'b0;
      #1;
      chk(fu_active == NF'(1 << e), "R8 active set", 32'(fu_active), 32'(1 << e));
      chk(fu_req_valid == '0, "R7 no request while busy", 32'(fu_req_valid), 0);
      fu_res_valid[e] = 1'b1;
      fu_res_data[e*32 +: 32] = ~p;
      fu_res_tag[e*TW +: TW] = TW'(c);
      #1;
      chk(rsp_valid == NC'(1 << c) && !rsp_err[c] && rsp_data[c*32 +: 32] == ~p, "R3 return",
          rsp_data[c*32 +: 32], ~p);
      @(posedge clk);
      @(negedge clk);
      fu_res_valid[e] = 1'b0;
      #1;
      chk(fu_active == '0, "R8 active clear", 32'(fu_active), 0);
    end else begin
      chk(fu_req_valid == '0 && call_ready[c], "R4 miss accepted", 32'(fu_req_valid), 0);
      @(posedge clk);
      @(negedge clk);
      call_valid[c] = 1'b0;
      #1;
      chk(rsp_valid == NC'(1 << c) && rsp_err[c] && rsp_data[c*32 +: 32] == 0, "R4 error response",
          {rsp_err[c], 27'd0, rsp_valid}, {1'b1, 27'd0, 4'(1 << c)});
      @(posedge clk);
      @(negedge clk);
      #1;
      chk(rsp_valid == '0, "R4 error response single", 32'(rsp_valid), 0);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(fu_req_valid == '0 && rsp_valid == '0, "R7 reset idle", 32'(fu_req_valid), 0);
    chk(fu_active == '0, "R8 reset active", 32'(fu_active), 0);

    // sweep: every caller, method and class
    for (int c = 0; c < NC; c++)
      for (int m = 0; m < 16; m++)
        for (int k = 0; k < 16; k++)
          one_call(c, m, k);

    // R5: all callers request unit 0, pointer starts at caller 0
    @(negedge clk);
    for (int c = 0; c < NC; c++) set_call(c, 1, 0, 8'(c), 32'h100 + 32'(c));
    for (int i = 0; i < NC; i++) begin
      #1;
      chk(fu_req_valid[0] && fu_req_tag[1:0] == 2'(i), "R5 round-robin order",
          32'(fu_req_tag[1:0]), 32'(i));
      @(posedge clk);
      @(negedge clk);
      call_valid[i] = 1'b0;
      #1;
      chk(fu_req_valid[0] == 1'b0 && (call_ready & call_valid) == '0, "R7 callers stalled",
          32'(call_ready & call_valid), 0);
      fu_res_valid[0] = 1'b1;
      fu_res_data[31:0] = 32'h200 + 32'(i);
      fu_res_tag[1:0] = 2'(i);
      @(posedge clk);
      @(negedge clk);
      fu_res_valid[0] = 1'b0;
    end

    // R6: held path on unit 1, then R9 return back-pressure
    fu_req_ready[1] = 1'b0;
    set_call(2, 1, 1, 8'h22, 32'hCAFE_0002);
    @(posedge clk);
    @(negedge clk);
    set_call(0, 1, 1, 8'h00, 32'hCAFE_0000);
    for (int i = 0; i < 3; i++) begin
      #1;
      chk(fu_req_valid[1] && fu_req_tag[3:2] == 2'd2 && fu_req_param[63:32] == 32'hCAFE_0002,
          "R6 path held", fu_req_param[63:32], 32'hCAFE_0002);
      @(posedge clk);
      @(negedge clk);
    end
    fu_req_ready[1] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    call_valid[2] = 1'b0;
    rsp_ready[2] = 1'b0;
    fu_res_valid[1] = 1'b1;
    fu_res_data[63:32] = 32'h5151_0002;
    fu_res_tag[3:2] = 2'd2;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk(rsp_valid[2] && rsp_data[95:64] == 32'h5151_0002 && !fu_res_ready[1], "R9 response held",
          rsp_data[95:64], 32'h5151_0002);
      chk(fu_active[1] && !fu_req_valid[1] && !call_ready[0], "R8 R7 busy during back-pressure",
          {fu_active[1], fu_req_valid[1], call_ready[0]}, 32'h4);
      @(posedge clk);
      @(negedge clk);
    end
    rsp_ready[2] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    fu_res_valid[1] = 1'b0;
    #1;
    chk(fu_req_valid[1] && fu_req_tag[3:2] == 2'd0, "R5 waiting caller served",
        32'(fu_req_tag[3:2]), 0);
    @(posedge clk);
    @(negedge clk);
    call_valid[0] = 1'b0;
    fu_res_valid[1] = 1'b1;
    fu_res_tag[3:2] = 2'd0;
    fu_res_data[63:32] = 32'h5151_0000;
    #1;
    chk(rsp_valid[0] && rsp_data[31:0] == 32'h5151_0000, "R3 second return",
        rsp_data[31:0], 32'h5151_0000);
    @(posedge clk);
    @(negedge clk);
    fu_res_valid[1] = 1'b0;
    #1;
    chk(fu_active == '0, "R8 final idle", 32'(fu_active), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule